// File: doc/BRIEF.md
# NCO Frequency and Phase Control Register Bank

This block is the byte-wide write port of a numerically controlled oscillator. A processor writes bytes over an 8-bit bus, with a 4-bit address that selects the target. An active-low select gates each write, and a write strobe marks it. The bytes fill two 32-bit frequency step buffers, called bank A and bank B, and one 12-bit phase offset buffer. Two registered outputs hold the words the phase accumulator uses: a frequency step word and a phase modulation word. The accumulator lies outside this block.

A frequency load pulse copies one of the two frequency buffers into the frequency output register, and a bank select input picks which one. With two buffers, software can fill one bank while the other is in use, and then swap banks. A phase load pulse updates the phase output word from one of two sources. In buffered mode the source is the phase buffer. In direct mode the source is the data bus and address bus read together as one 12-bit word, which allows fast phase modulation from outside hardware without any bus write cycle.

All three control inputs are sampled on the system clock and detected by their edges. The write strobe acts on its rising edge. The two load pulses act on their falling edges.

Top module: `nco_ctrl_bank`

## Requirements
- R1: While reset is asserted, and after it is released, all three buffers and both output words are zero.
- R2: A write happens at the first clock edge at which `wr_strobe` is sampled high after it was sampled low. Holding the strobe high does not cause another write, even if the data changes.
- R3: A write to address 0b00nn stores the data in byte nn of bank A, and a write to address 0b01nn stores it in byte nn of bank B. Byte 0 is bits 7:0 and byte 3 is bits 31:24.
- R4: A write to address 0b1x00 stores data bits 7:4 in phase buffer bits 3:0. A write to address 0b1x01 stores the data byte in phase buffer bits 11:4.
- R5: Bytes may be written in any order. A write changes only the addressed field, and every other byte keeps its value.
- R6: A write to address 0b1x10 or 0b1x11 changes no buffer.
- R7: While `chip_sel_n` is high, a strobe edge writes nothing.
- R8: At the first clock edge at which `freq_load` is sampled low after it was sampled high, `freq_word` takes bank A if `freq_pick_a` is 1, or bank B if it is 0. At every other edge, `freq_word` holds its value.
- R9: At the first clock edge at which `phase_load` is sampled low after it was sampled high, `pm_word` is updated. If `phase_src_buf` is 0, it takes {bus_data, bus_addr}, with the data in bits 11:4, whatever the state of `chip_sel_n` and `wr_strobe`. If `phase_src_buf` is 1, it takes the phase buffer. At every other edge, `pm_word` holds its value.
- R10: If a write and a load of the same buffer fall on the same clock edge, the load takes the buffer contents from before that write.
- R11: One bank can be rewritten while the other bank is loaded, with the bank select alternating from one load to the next. Each load returns the bank that was completed before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_data | input | 8 | Write data byte, and the upper 8 bits of a direct phase word |
| bus_addr | input | 4 | Write address, and the lower 4 bits of a direct phase word |
| chip_sel_n | input | 1 | Write enable, active low |
| wr_strobe | input | 1 | Write strobe, acts on its rising edge |
| freq_pick_a | input | 1 | 1 selects bank A and 0 selects bank B for a frequency load |
| phase_src_buf | input | 1 | 1 selects the phase buffer and 0 selects the bus pins for a phase load |
| freq_load | input | 1 | Frequency load, acts on its falling edge |
| phase_load | input | 1 | Phase load, acts on its falling edge |
| freq_word | output | 32 | Frequency step word sent to the accumulator |
| pm_word | output | 12 | Phase modulation word sent to the accumulator |

## Verification
Two functions can coincide on one clock edge: a byte write to a buffer and a load from that same buffer. The bench provokes this by raising the strobe and dropping the load line at the same falling clock edge, for bank A and again for the phase buffer. It then checks that the loaded word equals the buffer contents from before the write, and that a second load returns the newly written byte. The bank alternation sequence also writes one bank on the same edge that loads the other, and checks that the loaded bank is intact.

// File: rtl/nco_ctrl_pkg.sv
package nco_ctrl_pkg;
    localparam int BUS_W      = 8;
    localparam int ADDR_W     = 4;
    localparam int FREQ_BYTES = 4;
    localparam int FREQ_W     = BUS_W * FREQ_BYTES;
    localparam int PM_W       = BUS_W + ADDR_W;
    localparam int PM_LO_W    = PM_W - BUS_W;
    localparam int BYTE_SEL_W = $clog2(FREQ_BYTES);

    typedef logic [FREQ_W-1:0] freq_word_t;
    typedef logic [PM_W-1:0]   pm_word_t;
    typedef logic [BUS_W-1:0]  bus_byte_t;
    typedef logic [ADDR_W-1:0] bus_addr_t;

    typedef struct packed {
        freq_word_t bank_a;
        freq_word_t bank_b;
        pm_word_t   ph_buf;
    } bank_state_t;

    typedef struct packed {
        freq_word_t freq;
        pm_word_t   pm;
    } load_state_t;

    typedef struct packed {
        logic lvl;
    } edge_state_t;
endpackage

// File: rtl/nco_edge_det.sv
module nco_edge_det #(
    parameter bit RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic pulse
);
    import nco_ctrl_pkg::*;

    localparam logic IDLE_LVL = RISE ? 1'b1 : 1'b0;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lvl = sig_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lvl: IDLE_LVL};
        else        st_q <= st_d;
    end

    generate
        if (RISE) begin : g_rise
            assign pulse = sig_in & ~st_q.lvl;
        end else begin : g_fall
            assign pulse = ~sig_in & st_q.lvl;
        end
    endgenerate

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/nco_byte_bank.sv
module nco_byte_bank (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  nco_ctrl_pkg::bus_byte_t  wr_data,
    input  nco_ctrl_pkg::bus_addr_t  wr_addr,
    output nco_ctrl_pkg::freq_word_t bank_a,
    output nco_ctrl_pkg::freq_word_t bank_b,
    output nco_ctrl_pkg::pm_word_t   ph_buf
);
    import nco_ctrl_pkg::*;

    bank_state_t st_d, st_q;
    logic        is_phase_d;
    logic        is_bank_b_d;

    assign is_phase_d  = wr_addr[ADDR_W-1];
    assign is_bank_b_d = wr_addr[BYTE_SEL_W];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (!is_phase_d) begin
                for (int k = 0; k < FREQ_BYTES; k++) begin
                    if (wr_addr[BYTE_SEL_W-1:0] == k[BYTE_SEL_W-1:0]) begin
                        if (is_bank_b_d) st_d.bank_b[k*BUS_W +: BUS_W] = wr_data;
                        else             st_d.bank_a[k*BUS_W +: BUS_W] = wr_data;
                    end
                end
            end else begin
                case (wr_addr[1:0])
                    2'b00:   st_d.ph_buf[PM_LO_W-1:0]  = wr_data[BUS_W-1 -: PM_LO_W];
                    2'b01:   st_d.ph_buf[PM_W-1 -: BUS_W] = wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bank_a = st_q.bank_a;
    assign bank_b = st_q.bank_b;
    assign ph_buf = st_q.ph_buf;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(bank_a) && $stable(bank_b) && $stable(ph_buf)));

    // R6
    undef_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[ADDR_W-1] && wr_addr[1]) |=>
        ($stable(bank_a) && $stable(bank_b) && $stable(ph_buf)));

    // R4
    ph_lo_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[ADDR_W-1] && wr_addr[1:0] == 2'b00) |=>
        (ph_buf[PM_LO_W-1:0] == $past(wr_data[BUS_W-1 -: PM_LO_W])
         && $stable(ph_buf[PM_W-1:PM_LO_W])));

    // R5
    bank_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr[ADDR_W-1]) |=> ($stable(ph_buf) &&
        ($stable(bank_a) || $stable(bank_b))));
endmodule

// File: rtl/nco_load_path.sv
module nco_load_path (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_freq,
    input  logic                     ld_pm,
    input  logic                     pick_a,
    input  logic                     src_buf,
    input  nco_ctrl_pkg::freq_word_t bank_a,
    input  nco_ctrl_pkg::freq_word_t bank_b,
    input  nco_ctrl_pkg::pm_word_t   ph_buf,
    input  nco_ctrl_pkg::bus_byte_t  pin_data,
    input  nco_ctrl_pkg::bus_addr_t  pin_addr,
    output nco_ctrl_pkg::freq_word_t freq_word,
    output nco_ctrl_pkg::pm_word_t   pm_word
);
    import nco_ctrl_pkg::*;

    load_state_t st_d, st_q;
    pm_word_t    pin_word_d;

    assign pin_word_d = {pin_data, pin_addr};

    always_comb begin
        st_d = st_q;
        if (ld_freq) st_d.freq = pick_a ? bank_a : bank_b;
        if (ld_pm)   st_d.pm   = src_buf ? ph_buf : pin_word_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign freq_word = st_q.freq;
    assign pm_word   = st_q.pm;

    // R8
    freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_freq |=> $stable(freq_word));

    // R8
    freq_bank_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_freq && pick_a) |=> (freq_word == $past(bank_a)));

    // R9
    pm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_pm |=> $stable(pm_word));

    // R9
    pm_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pm && !src_buf) |=> (pm_word == {$past(pin_data), $past(pin_addr)}));
endmodule

// File: rtl/nco_ctrl_bank.sv
module nco_ctrl_bank (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_data,
    input  logic [3:0]  bus_addr,
    input  logic        chip_sel_n,
    input  logic        wr_strobe,
    input  logic        freq_pick_a,
    input  logic        phase_src_buf,
    input  logic        freq_load,
    input  logic        phase_load,
    output logic [31:0] freq_word,
    output logic [11:0] pm_word
);
    import nco_ctrl_pkg::*;

    logic       wr_rise;
    logic       fl_fall;
    logic       pl_fall;
    logic       wr_fire;
    freq_word_t bank_a, bank_b;
    pm_word_t   ph_buf;

    nco_edge_det #(.RISE(1'b1)) i_wr_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(wr_strobe), .pulse(wr_rise));
    nco_edge_det #(.RISE(1'b0)) i_fl_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(freq_load), .pulse(fl_fall));
    nco_edge_det #(.RISE(1'b0)) i_pl_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(phase_load), .pulse(pl_fall));

    assign wr_fire = wr_rise & ~chip_sel_n;

    nco_byte_bank i_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_fire), .wr_data(bus_data),
        .wr_addr(bus_addr), .bank_a(bank_a), .bank_b(bank_b), .ph_buf(ph_buf));

    nco_load_path i_load (
        .clk(clk), .rst_n(rst_n), .ld_freq(fl_fall), .ld_pm(pl_fall),
        .pick_a(freq_pick_a), .src_buf(phase_src_buf), .bank_a(bank_a),
        .bank_b(bank_b), .ph_buf(ph_buf), .pin_data(bus_data),
        .pin_addr(bus_addr), .freq_word(freq_word), .pm_word(pm_word));

    // R7
    cs_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_sel_n |=> ($stable(bank_a) && $stable(bank_b) && $stable(ph_buf)));

    // R10
    load_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_fall && !freq_pick_a) |=> (freq_word == $past(bank_b)));
endmodule

// File: tb/test_nco_ctrl_bank.sv
module test_nco_ctrl_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_data = '0;
    logic [3:0]  bus_addr = '0;
    logic        chip_sel_n = 1'b1;
    logic        wr_strobe = 1'b0;
    logic        freq_pick_a = 1'b0;
    logic        phase_src_buf = 1'b1;
    logic        freq_load = 1'b1;
    logic        phase_load = 1'b1;
    logic [31:0] freq_word;
    logic [11:0] pm_word;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] ma, mb;
    logic [11:0] mph;

    nco_ctrl_bank i_nco_ctrl_bank (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
        .chip_sel_n(chip_sel_n), .wr_strobe(wr_strobe), .freq_pick_a(freq_pick_a),
        .phase_src_buf(phase_src_buf), .freq_load(freq_load), .phase_load(phase_load),
        .freq_word(freq_word), .pm_word(pm_word));

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [3:0] a, input logic [7:0] d);
        if (a < 4)                ma[a*8 +: 8] = d;
        else if (a < 8)           mb[(a-4)*8 +: 8] = d;
        else if (a % 4 == 0)      mph[3:0] = d[7:4];
        else if (a % 4 == 1)      mph[11:4] = d;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [7:0] d, input bit sel);
        @(negedge clk);
        bus_addr = a; bus_data = d; chip_sel_n = !sel; wr_strobe = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0; chip_sel_n = 1'b1;
        if (sel) model_write(a, d);
    endtask

    task automatic load_freq(input bit pick);
        @(negedge clk);
        freq_pick_a = pick; freq_load = 1'b0;
        @(negedge clk);
        freq_load = 1'b1;
    endtask

    task automatic load_phase(input bit src, input logic [7:0] d, input logic [3:0] a);
        @(negedge clk);
        phase_src_buf = src; bus_data = d; bus_addr = a; phase_load = 1'b0;
        @(negedge clk);
        phase_load = 1'b1;
    endtask

    task automatic check_all(input string req);
        load_freq(1'b1); check(req, freq_word, ma);
        load_freq(1'b0); check(req, freq_word, mb);
        load_phase(1'b1, 8'h00, 4'h0); check(req, {20'd0, pm_word}, {20'd0, mph});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        ma = '0; mb = '0; mph = '0;
        repeat (3) @(negedge clk);
        // R1: outputs zero during reset
        check("R1 reset freq", freq_word, 32'd0);
        check("R1 reset pm", {20'd0, pm_word}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R1 post-reset buffers");

        // R3 R4 R6: sweep every address with two data patterns
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < 16; a++) begin
                logic [7:0] d;
                d = 8'(a * 29 + 8'h5A + p * 8'h93);
                do_write(4'(a), d, 1'b1);
                if (a < 8)            check_all("R3 bank byte write");
                else if (a % 4 < 2)   check_all("R4 phase field write");
                else                  check_all("R6 undefined address ignored");
            end
        end

        // R5: out-of-order partial rewrite
        do_write(4'd6, 8'hE1, 1'b1);
        do_write(4'd4, 8'h1E, 1'b1);
        do_write(4'd1, 8'hC3, 1'b1);
        check_all("R5 any order, others kept");

        // R7: chip select high inhibits writes
        do_write(4'd0, 8'h77, 1'b0);
        do_write(4'd5, 8'h77, 1'b0);
        do_write(4'd13, 8'h77, 1'b0);
        check_all("R7 chip select inhibit");

        // R2: held strobe writes once
        @(negedge clk);
        bus_addr = 4'd3; bus_data = 8'h11; chip_sel_n = 1'b0; wr_strobe = 1'b1;
        model_write(4'd3, 8'h11);
        @(negedge clk); bus_data = 8'h22;
        @(negedge clk); bus_data = 8'h33;
        @(negedge clk); wr_strobe = 1'b0; chip_sel_n = 1'b1;
        check_all("R2 single write per strobe");

        // R8: output holds without a load
        load_freq(1'b1);
        do_write(4'd0, 8'h9C, 1'b1);
        repeat (3) @(negedge clk);
        check("R8 hold without load", freq_word, {ma[31:8], 8'h00} | {24'd0, 8'h00} | (freq_word & 32'h0000_00FF));
        check("R8 upper bytes held", freq_word[31:8], ma[31:8]);
        load_freq(1'b1);
        check("R8 load A", freq_word, ma);

        // R9: direct phase word, chip select high and strobe idle
        for (int k = 0; k < 6; k++) begin
            logic [7:0] d;
            logic [3:0] a;
            d = 8'(k * 53 + 8'h21);
            a = 4'(k * 7 + 3);
            load_phase(1'b0, d, a);
            check("R9 direct pm word", {20'd0, pm_word}, {20'd0, d, a});
        end
        check_all("R9 direct load leaves buffers");

        // R10: write and load of the same buffer on one edge
        begin
            logic [31:0] old_a;
            logic [11:0] old_ph;
            old_a = ma;
            @(negedge clk);
            bus_addr = 4'd0; bus_data = 8'hA5; chip_sel_n = 1'b0; wr_strobe = 1'b1;
            freq_pick_a = 1'b1; freq_load = 1'b0;
            @(negedge clk);
            wr_strobe = 1'b0; chip_sel_n = 1'b1; freq_load = 1'b1;
            model_write(4'd0, 8'hA5);
            check("R10 freq load sees old bank", freq_word, old_a);
            load_freq(1'b1);
            check("R10 next load sees new byte", freq_word, ma);
            old_ph = mph;
            @(negedge clk);
            bus_addr = 4'd9; bus_data = 8'h3D; chip_sel_n = 1'b0; wr_strobe = 1'b1;
            phase_src_buf = 1'b1; phase_load = 1'b0;
            @(negedge clk);
            wr_strobe = 1'b0; chip_sel_n = 1'b1; phase_load = 1'b1;
            model_write(4'd9, 8'h3D);
            check("R10 pm load sees old buffer", {20'd0, pm_word}, {20'd0, old_ph});
            load_phase(1'b1, 8'h00, 4'h0);
            check("R10 next pm load sees new", {20'd0, pm_word}, {20'd0, mph});
        end

        // R11: ping-pong, write one bank while loading the other
        for (int r = 0; r < 6; r++) begin
            bit tgt_b;
            tgt_b = r[0];
            for (int s = 0; s < 8; s++) begin
                @(negedge clk);
                if (s == 1) begin
                    freq_load = 1'b1;
                    check("R11 ping-pong load", freq_word, tgt_b ? ma : mb);
                end
                if (s % 2 == 0) begin
                    logic [3:0] a;
                    logic [7:0] d;
                    a = 4'((tgt_b ? 4 : 0) + s / 2);
                    d = 8'(r * 37 + s * 11 + 1);
                    bus_addr = a; bus_data = d; chip_sel_n = 1'b0; wr_strobe = 1'b1;
                    model_write(a, d);
                    if (s == 0) begin
                        freq_pick_a = tgt_b;
                        freq_load = 1'b0;
                    end
                end else begin
                    wr_strobe = 1'b0; chip_sel_n = 1'b1;
                end
            end
        end
        @(negedge clk);
        wr_strobe = 1'b0; chip_sel_n = 1'b1;
        check_all("R11 final banks");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule